// File: doc/BRIEF.md
# Dual-Speed Memory Access Arbiter

This block routes every memory access from a CPU and from a DMA requester to one of two memory domains. A fast domain serves most banks. A slow domain runs at roughly three eighths of the fast rate and holds two banks. Each access is classified by its bank byte. Accesses to the two slow banks go to the slow port. CPU writes that land in a shadowed window of the two lowest banks go to both ports. Every other access stays on the fast port.

Slow-port work is only issued on a slow-cycle tick. A fractional phase accumulator produces that tick three times in every eight fast cycles. An 8-bit speed register chooses whether the CPU runs at full rate or is paced by the tick. A second register supplies the bank byte for DMA accesses, because DMA only carries a 16-bit offset.

DMA is accepted on tick cycles only, and it wins against the CPU. If a tick with a pending DMA request lands in the middle of a multi-cycle fast CPU access, that access is abandoned and restarted from its first cycle. The CPU is held off through a ready output.

Top module: `speed_arbiter`

## Requirements
- R1: The speed register resets to 0x80 and the DMA bank register resets to 0x00. A write to either register stores all eight bits, and the stored value appears on its read-back output from the next cycle. Bit 7 of the speed register set to 1 means fast CPU operation.
- R2: With the default ratio (3/8), the internal slow tick sits at cycle index n mod 8 in {2, 5, 7}, with n counted from 0 in the first cycle after reset. A tick fires whenever (3*n mod 8) is 5 or more. The tick is never high in two consecutive cycles.
- R3: In fast mode, a CPU access to a bank other than 0xE0/0xE1 that is not a shadowed write completes after exactly FAST_LAT cycles. It pulses fm_en in its last cycle with fm_addr equal to cpu_addr, and it never touches the slow port.
- R4: A CPU access to bank 0xE0 or 0xE1 uses the slow port only. It completes in the first tick cycle at or after the request. sm_addr is {cpu_addr[16], cpu_addr[15:0]}, and read data is returned from sm_rdata.
- R5: A CPU write to bank 0x00 or 0x01 with an offset in [SHADOW_LO, SHADOW_HI] completes on a tick. In that cycle both fm_en and sm_en are raised, and sm_addr carries the bank's bit 0. A read from the same window is an ordinary fast access.
- R6: With speed bit 7 cleared, a CPU access to a fast-domain bank waits for a tick and then completes through the fast port in that tick cycle.
- R7: cpu_rdy is high whenever no CPU request is present. While a request is pending, cpu_rdy is low in every cycle except the one in which the access completes.
- R8: A DMA request completes only in a tick cycle. When the DMA bank register holds a fast bank, fm_addr is {bank register, dma_addr}. When it holds 0xE0 or 0xE1, the slow port is used with sm_addr {bank bit 0, dma_addr}.
- R9: When a CPU request and a DMA request are both present in a tick cycle, only the DMA access is performed. The CPU request stays pending until a later completion.
- R10: A tick with a DMA request that occurs during an unfinished fast CPU access aborts that access. The CPU access performs no fast-port cycle in that tick. It then needs a full FAST_LAT cycles again after the DMA access is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU access request, held until cpu_rdy |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_addr | input | 24 | CPU address, bank byte in bits 23:16 |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, valid in the completing cycle |
| cpu_rdy | output | 1 | Low while a CPU access is stalled |
| dma_req | input | 1 | DMA access request, held until dma_rdy |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_addr | input | 16 | DMA offset within the register-selected bank |
| dma_wdata | input | 8 | DMA write data |
| dma_rdata | output | 8 | DMA read data, valid in the completing cycle |
| dma_rdy | output | 1 | Low while a DMA access is waiting |
| spd_we | input | 1 | Write strobe for the speed register |
| bank_we | input | 1 | Write strobe for the DMA bank register |
| reg_wdata | input | 8 | Data for either register write |
| spd_q | output | 8 | Speed register contents |
| dbank_q | output | 8 | DMA bank register contents |
| fm_en | output | 1 | Fast-port access strobe |
| fm_we | output | 1 | Fast-port write |
| fm_addr | output | 24 | Fast-port address |
| fm_wdata | output | 8 | Fast-port write data |
| fm_rdata | input | 8 | Fast-port read data |
| sm_en | output | 1 | Slow-port access strobe |
| sm_we | output | 1 | Slow-port write |
| sm_addr | output | 17 | Slow-port address: bank bit and offset |
| sm_wdata | output | 8 | Slow-port write data |
| sm_rdata | input | 8 | Slow-port read data |

## Verification
The bench builds the block with FAST_LAT set to 3 and keeps the default 3/8 tick ratio and shadow window. A three-cycle fast access leaves room for a DMA tick to fall on its second cycle. The bench can then tell a restarted access, which finishes three cycles after the DMA, from one that resumes and finishes two cycles after it. Holding the ratio at its default fixes the tick positions at 2, 5 and 7 of every eight cycles. The bench uses those positions to predict every paced completion and to line up the collision and abort cases.

// File: rtl/spdarb_pkg.sv
package spdarb_pkg;

    localparam int BANK_W = 8;
    localparam int OFS_W  = 16;
    localparam int ADDR_W = BANK_W + OFS_W;
    localparam int DATA_W = 8;
    localparam int SADDR_W = OFS_W + 1;

    localparam int               SPEED_FAST_BIT = 7;
    localparam logic [DATA_W-1:0] SPEED_RESET   = 8'h80;
    localparam logic [DATA_W-1:0] DBANK_RESET   = 8'h00;

    typedef enum logic [1:0] {
        ROUTE_FAST   = 2'd0,
        ROUTE_PACED  = 2'd1,
        ROUTE_SLOW   = 2'd2,
        ROUTE_SHADOW = 2'd3
    } route_e;

    typedef struct packed {
        logic              en;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } fast_op_t;

    typedef struct packed {
        logic               en;
        logic               we;
        logic [SADDR_W-1:0] addr;
        logic [DATA_W-1:0]  wdata;
    } slow_op_t;

    function automatic logic in_slow_bank(input logic [BANK_W-1:0] bank);
        return bank[BANK_W-1:1] == 7'b1110000;
    endfunction

    function automatic logic in_low_bank(input logic [BANK_W-1:0] bank);
        return bank[BANK_W-1:1] == 7'b0000000;
    endfunction

    function automatic logic [SADDR_W-1:0] slow_addr(input logic bank_lsb,
                                                     input logic [OFS_W-1:0] ofs);
        return {bank_lsb, ofs};
    endfunction

endpackage

// File: rtl/spdarb_phase.sv
module spdarb_phase #(
    parameter int NUM = 3,
    parameter int DEN = 8
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int ACC_W = $clog2(DEN) + 1;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] sum;

    always_comb begin
        sum  = acc + ACC_W'(NUM);
        tick = (sum >= ACC_W'(DEN));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (tick) begin
            acc <= sum - ACC_W'(DEN);
        end else begin
            acc <= sum;
        end
    end
endmodule

// File: rtl/spdarb_regs.sv
module spdarb_regs
    import spdarb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              spd_we,
    input  logic              bank_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] spd_q,
    output logic [DATA_W-1:0] dbank_q,
    output logic              fast_mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            spd_q   <= SPEED_RESET;
            dbank_q <= DBANK_RESET;
        end else begin
            if (spd_we)  spd_q   <= wdata;
            if (bank_we) dbank_q <= wdata;
        end
    end

    assign fast_mode = spd_q[SPEED_FAST_BIT];
endmodule

// File: rtl/spdarb_decode.sv
module spdarb_decode
    import spdarb_pkg::*;
#(
    parameter logic [OFS_W-1:0] SHADOW_LO = 16'h0400,
    parameter logic [OFS_W-1:0] SHADOW_HI = 16'h07FF
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic              fast_mode,
    output route_e            route
);
    logic [BANK_W-1:0] bank;
    logic [OFS_W-1:0]  ofs;
    logic              in_window;

    always_comb begin
        bank      = addr[ADDR_W-1:OFS_W];
        ofs       = addr[OFS_W-1:0];
        in_window = in_low_bank(bank) && (ofs >= SHADOW_LO) && (ofs <= SHADOW_HI);
        if (in_slow_bank(bank)) begin
            route = ROUTE_SLOW;
        end else if (we && in_window) begin
            route = ROUTE_SHADOW;
        end else if (!fast_mode) begin
            route = ROUTE_PACED;
        end else begin
            route = ROUTE_FAST;
        end
    end
endmodule

// File: rtl/speed_arbiter.sv
module speed_arbiter
    import spdarb_pkg::*;
#(
    parameter int               FAST_LAT  = 2,
    parameter int               TICK_NUM  = 3,
    parameter int               TICK_DEN  = 8,
    parameter logic [15:0]      SHADOW_LO = 16'h0400,
    parameter logic [15:0]      SHADOW_HI = 16'h07FF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [23:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    output logic [7:0]  cpu_rdata,
    output logic        cpu_rdy,
    input  logic        dma_req,
    input  logic        dma_we,
    input  logic [15:0] dma_addr,
    input  logic [7:0]  dma_wdata,
    output logic [7:0]  dma_rdata,
    output logic        dma_rdy,
    input  logic        spd_we,
    input  logic        bank_we,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  spd_q,
    output logic [7:0]  dbank_q,
    output logic        fm_en,
    output logic        fm_we,
    output logic [23:0] fm_addr,
    output logic [7:0]  fm_wdata,
    input  logic [7:0]  fm_rdata,
    output logic        sm_en,
    output logic        sm_we,
    output logic [16:0] sm_addr,
    output logic [7:0]  sm_wdata,
    input  logic [7:0]  sm_rdata
);
    localparam int CNT_W = $clog2(FAST_LAT + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FAST_LAT - 1);

    logic     slow_tick;
    logic     fast_mode;
    route_e   cpu_route;
    logic     dma_go;
    logic     dma_slow;
    logic     cpu_done;
    logic     cpu_is_fast;
    logic [CNT_W-1:0] lat_cnt;
    fast_op_t fop;
    slow_op_t sop;

    spdarb_phase #(.NUM(TICK_NUM), .DEN(TICK_DEN)) phase_i (
        .clk  (clk),
        .rst  (rst),
        .tick (slow_tick)
    );

    spdarb_regs regs_i (
        .clk       (clk),
        .rst       (rst),
        .spd_we    (spd_we),
        .bank_we   (bank_we),
        .wdata     (reg_wdata),
        .spd_q     (spd_q),
        .dbank_q   (dbank_q),
        .fast_mode (fast_mode)
    );

    spdarb_decode #(.SHADOW_LO(SHADOW_LO), .SHADOW_HI(SHADOW_HI)) dec_i (
        .we        (cpu_we),
        .addr      (cpu_addr),
        .fast_mode (fast_mode),
        .route     (cpu_route)
    );

    // DMA is only admitted on a slow tick and takes priority over the CPU.
    always_comb begin
        dma_go      = dma_req && slow_tick;
        dma_slow    = in_slow_bank(dbank_q);
        cpu_is_fast = (cpu_route == ROUTE_FAST);
        if (!cpu_req || dma_go) begin
            cpu_done = 1'b0;
        end else if (cpu_is_fast) begin
            cpu_done = (lat_cnt == LAST_CNT);
        end else begin
            cpu_done = slow_tick;
        end
    end

    // Fast-access progress; cleared by completion or by a DMA abort.
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_cnt <= '0;
        end else if (!cpu_req || !cpu_is_fast || cpu_done || dma_go) begin
            lat_cnt <= '0;
        end else begin
            lat_cnt <= lat_cnt + 1'b1;
        end
    end

    always_comb begin
        fop = '0;
        sop = '0;
        if (dma_go) begin
            if (dma_slow) begin
                sop.en    = 1'b1;
                sop.we    = dma_we;
                sop.addr  = slow_addr(dbank_q[0], dma_addr);
                sop.wdata = dma_wdata;
            end else begin
                fop.en    = 1'b1;
                fop.we    = dma_we;
                fop.addr  = {dbank_q, dma_addr};
                fop.wdata = dma_wdata;
            end
        end else if (cpu_done) begin
            fop.we    = cpu_we;
            fop.addr  = cpu_addr;
            fop.wdata = cpu_wdata;
            sop.we    = cpu_we;
            sop.addr  = slow_addr(cpu_addr[OFS_W], cpu_addr[OFS_W-1:0]);
            sop.wdata = cpu_wdata;
            unique case (cpu_route)
                ROUTE_FAST, ROUTE_PACED: fop.en = 1'b1;
                ROUTE_SLOW:              sop.en = 1'b1;
                ROUTE_SHADOW: begin
                    fop.en = 1'b1;
                    sop.en = 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign fm_en    = fop.en;
    assign fm_we    = fop.we;
    assign fm_addr  = fop.addr;
    assign fm_wdata = fop.wdata;
    assign sm_en    = sop.en;
    assign sm_we    = sop.we;
    assign sm_addr  = sop.addr;
    assign sm_wdata = sop.wdata;

    assign cpu_rdy   = !cpu_req || cpu_done;
    assign dma_rdy   = !dma_req || dma_go;
    assign cpu_rdata = (cpu_route == ROUTE_SLOW) ? sm_rdata : fm_rdata;
    assign dma_rdata = dma_slow ? sm_rdata : fm_rdata;
endmodule

// File: rtl/spdarb_chk.sv
module spdarb_chk #(
    parameter int LAT = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       slow_tick,
    input logic       cpu_req,
    input logic       cpu_rdy,
    input logic       dma_req,
    input logic       dma_rdy,
    input logic       fm_en,
    input logic       sm_en,
    input logic [7:0] spd_q
);
    // R1: speed register holds its reset value right after reset
    a_r1_reset_speed: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> spd_q == 8'h80);

    // R2: ticks never come back to back
    a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        slow_tick |=> !slow_tick);

    // R4: slow port is used only on a tick
    a_r4_slow_on_tick: assert property (@(posedge clk) disable iff (rst)
        sm_en |-> slow_tick);

    // R7: an idle CPU side is always ready
    a_r7_idle_ready: assert property (@(posedge clk) disable iff (rst)
        !cpu_req |-> cpu_rdy);

    // R8: DMA completes on a tick only
    a_r8_dma_on_tick: assert property (@(posedge clk) disable iff (rst)
        (dma_req && dma_rdy) |-> slow_tick);

    // R9: the CPU never completes while DMA owns the tick
    a_r9_cpu_yields: assert property (@(posedge clk) disable iff (rst)
        (dma_req && slow_tick) |-> !(cpu_req && cpu_rdy));

    generate
        if (LAT > 1) begin : g_lat
            // R3: an off-tick fast completion needs an earlier request cycle
            a_r3_fast_history: assert property (@(posedge clk) disable iff (rst)
                (cpu_req && cpu_rdy && fm_en && !slow_tick) |-> $past(cpu_req));
        end
    endgenerate
endmodule

bind speed_arbiter spdarb_chk #(.LAT(FAST_LAT)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .slow_tick (slow_tick),
    .cpu_req   (cpu_req),
    .cpu_rdy   (cpu_rdy),
    .dma_req   (dma_req),
    .dma_rdy   (dma_rdy),
    .fm_en     (fm_en),
    .sm_en     (sm_en),
    .spd_q     (spd_q)
);

// File: tb/speed_arbiter_tb_top.sv
module speed_arbiter_tb_top;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_rdy;
    logic        dma_req = 1'b0, dma_we = 1'b0;
    logic [15:0] dma_addr = '0;
    logic [7:0]  dma_wdata = '0;
    logic [7:0]  dma_rdata;
    logic        dma_rdy;
    logic        spd_we = 1'b0, bank_we = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  spd_q, dbank_q;
    logic        fm_en, fm_we, sm_en, sm_we;
    logic [23:0] fm_addr;
    logic [16:0] sm_addr;
    logic [7:0]  fm_wdata, sm_wdata, fm_rdata, sm_rdata;

    int checks = 0;
    int errors = 0;
    int unsigned ncyc = 0;

    always #4 clk = ~clk;

    always @(posedge clk) if (!rst) ncyc <= ncyc + 1;

    assign fm_rdata = fm_addr[7:0] ^ fm_addr[23:16];
    assign sm_rdata = sm_addr[7:0] ^ 8'hC3 ^ {7'b0, sm_addr[16]};

    speed_arbiter #(.FAST_LAT(LAT)) dut_i (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_rdy(cpu_rdy),
        .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
        .dma_rdata(dma_rdata), .dma_rdy(dma_rdy),
        .spd_we(spd_we), .bank_we(bank_we), .reg_wdata(reg_wdata),
        .spd_q(spd_q), .dbank_q(dbank_q),
        .fm_en(fm_en), .fm_we(fm_we), .fm_addr(fm_addr), .fm_wdata(fm_wdata), .fm_rdata(fm_rdata),
        .sm_en(sm_en), .sm_we(sm_we), .sm_addr(sm_addr), .sm_wdata(sm_wdata), .sm_rdata(sm_rdata)
    );

    function automatic bit tick_at(input int unsigned n);
        return ((3 * n) % 8) >= 5;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input bit is_speed, input logic [7:0] val);
        @(negedge clk);
        spd_we = is_speed; bank_we = !is_speed; reg_wdata = val;
        @(negedge clk);
        spd_we = 1'b0; bank_we = 1'b0;
        #1;
        if (is_speed) check(spd_q == val, "R1", "speed readback", spd_q, val);
        else          check(dbank_q == val, "R1", "bank readback", dbank_q, val);
    endtask

    // Generic CPU access: exp_fast selects latency counting versus tick pacing.
    task automatic cpu_access(input bit we, input logic [23:0] addr, input logic [7:0] wd,
                              input bit exp_fast, input bit exp_fm, input bit exp_sm,
                              input string req);
        bit exp_done;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        for (int k = 0; k < 40; k++) begin
            #1;
            exp_done = exp_fast ? (k == LAT - 1) : tick_at(ncyc);
            check(cpu_rdy == exp_done, req, "cpu_rdy", cpu_rdy, exp_done);
            if (exp_done) begin
                check(fm_en == exp_fm, req, "fm_en", fm_en, exp_fm);
                check(sm_en == exp_sm, req, "sm_en", sm_en, exp_sm);
                if (exp_fm) check(fm_addr == addr, req, "fm_addr", fm_addr, addr);
                if (exp_sm) check(sm_addr == addr[16:0], req, "sm_addr", sm_addr, addr[16:0]);
                if (we) begin
                    if (exp_fm) check(fm_wdata == wd, req, "fm_wdata", fm_wdata, wd);
                    if (exp_sm) check(sm_wdata == wd, req, "sm_wdata", sm_wdata, wd);
                end else if (exp_sm) begin
                    check(cpu_rdata == (addr[7:0] ^ 8'hC3 ^ {7'b0, addr[16]}), req, "rdata",
                          cpu_rdata, addr[7:0] ^ 8'hC3 ^ {7'b0, addr[16]});
                end else begin
                    check(cpu_rdata == (addr[7:0] ^ addr[23:16]), req, "rdata",
                          cpu_rdata, addr[7:0] ^ addr[23:16]);
                end
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic dma_access(input bit we, input logic [15:0] addr, input logic [7:0] wd,
                              input logic [7:0] bank, input bit slow);
        bit exp_done;
        @(negedge clk);
        dma_req = 1'b1; dma_we = we; dma_addr = addr; dma_wdata = wd;
        for (int k = 0; k < 40; k++) begin
            #1;
            exp_done = tick_at(ncyc);
            check(dma_rdy == exp_done, "R8", "dma_rdy", dma_rdy, exp_done);
            if (exp_done) begin
                check(fm_en == !slow, "R8", "fm_en", fm_en, !slow);
                check(sm_en == slow, "R8", "sm_en", sm_en, slow);
                if (slow) check(sm_addr == {bank[0], addr}, "R8", "sm_addr", sm_addr, {bank[0], addr});
                else      check(fm_addr == {bank, addr}, "R8", "fm_addr", fm_addr, {bank, addr});
                if (!we && !slow)
                    check(dma_rdata == (addr[7:0] ^ bank), "R8", "dma_rdata", dma_rdata, addr[7:0] ^ bank);
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        dma_req = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check(spd_q == 8'h80, "R1", "speed reset", spd_q, 8'h80);
        check(dbank_q == 8'h00, "R1", "bank reset", dbank_q, 8'h00);
        check(cpu_rdy == 1'b1, "R7", "idle cpu_rdy", cpu_rdy, 1);
        check(fm_en == 1'b0 && sm_en == 1'b0, "R7", "idle ports", {fm_en, sm_en}, 0);
    endtask

    // R2: tick pattern observed through a continuously held DMA request
    task automatic t_tick_pattern();
        int seen = 0;
        write_reg(1'b0, 8'h23);
        @(negedge clk);
        dma_req = 1'b1; dma_we = 1'b0; dma_addr = 16'h0010;
        for (int k = 0; k < 16; k++) begin
            #1;
            check(dma_rdy == tick_at(ncyc), "R2", "tick position", dma_rdy, tick_at(ncyc));
            if (dma_rdy) seen++;
            @(negedge clk);
        end
        dma_req = 1'b0;
        check(seen == 6, "R2", "ticks per 16 cycles", seen, 6);
    endtask

    task automatic t_collision();
        do @(negedge clk); while (!tick_at(ncyc));
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 24'hE0_1234;
        dma_req = 1'b1; dma_we = 1'b0; dma_addr = 16'h0042;
        #1;
        check(dma_rdy == 1'b1, "R9", "dma wins", dma_rdy, 1);
        check(cpu_rdy == 1'b0, "R9", "cpu held", cpu_rdy, 0);
        check(sm_en == 1'b0 && fm_en == 1'b1, "R9", "only dma port", {fm_en, sm_en}, 2'b10);
        @(negedge clk);
        dma_req = 1'b0;
        for (int k = 0; k < 10; k++) begin
            #1;
            check(cpu_rdy == tick_at(ncyc), "R9", "cpu later tick", cpu_rdy, tick_at(ncyc));
            if (tick_at(ncyc)) begin
                check(sm_en == 1'b1, "R9", "cpu slow port", sm_en, 1);
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic t_abort();
        do @(negedge clk); while (tick_at(ncyc) || !tick_at(ncyc + 1));
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 24'h12_0077;
        #1;
        check(cpu_rdy == 1'b0, "R10", "first cycle", cpu_rdy, 0);
        @(negedge clk);
        dma_req = 1'b1; dma_we = 1'b1; dma_addr = 16'h0300; dma_wdata = 8'h9E;
        #1;
        check(dma_rdy == 1'b1, "R10", "dma on tick", dma_rdy, 1);
        check(cpu_rdy == 1'b0, "R10", "cpu aborted", cpu_rdy, 0);
        check(fm_addr == 24'h23_0300 && fm_we == 1'b1, "R10", "fast port owner", fm_addr, 24'h23_0300);
        @(negedge clk);
        dma_req = 1'b0;
        for (int k = 0; k < LAT; k++) begin
            #1;
            check(cpu_rdy == (k == LAT - 1), "R10", "restart count", cpu_rdy, k == LAT - 1);
            if (k == LAT - 1)
                check(fm_en == 1'b1 && fm_addr == 24'h12_0077, "R10", "retry addr", fm_addr, 24'h12_0077);
            @(negedge clk);
        end
        cpu_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_tick_pattern();
        cpu_access(1'b0, 24'h12_3456, 8'h00, 1'b1, 1'b1, 1'b0, "R3");
        cpu_access(1'b1, 24'h00_2000, 8'hA5, 1'b1, 1'b1, 1'b0, "R3");
        cpu_access(1'b0, 24'hE1_0401, 8'h00, 1'b0, 1'b0, 1'b1, "R4");
        cpu_access(1'b1, 24'hE0_8000, 8'h3C, 1'b0, 1'b0, 1'b1, "R4");
        cpu_access(1'b1, 24'h01_0450, 8'h66, 1'b0, 1'b1, 1'b1, "R5");
        cpu_access(1'b1, 24'h00_07FF, 8'h11, 1'b0, 1'b1, 1'b1, "R5");
        cpu_access(1'b0, 24'h00_0450, 8'h00, 1'b1, 1'b1, 1'b0, "R5");
        cpu_access(1'b1, 24'h00_0800, 8'h22, 1'b1, 1'b1, 1'b0, "R5");
        write_reg(1'b1, 8'h05);
        cpu_access(1'b0, 24'h12_0033, 8'h00, 1'b0, 1'b1, 1'b0, "R6");
        write_reg(1'b1, 8'hC1);
        cpu_access(1'b0, 24'h12_0034, 8'h00, 1'b1, 1'b1, 1'b0, "R6");
        dma_access(1'b0, 16'h1234, 8'h00, 8'h23, 1'b0);
        write_reg(1'b0, 8'hE0);
        dma_access(1'b1, 16'h0400, 8'h5A, 8'hE0, 1'b1);
        write_reg(1'b0, 8'h23);
        t_collision();
        t_abort();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule